// File: doc/BRIEF.md
# Multi-Channel Reloading Down-Counter Timer

This block is a memory-mapped timer with several identical channels. Each channel owns a 32-bit counter, a 32-bit reload value and a small control word. A running channel decrements its counter once every four clock cycles. When a count tick finds the counter at zero, the channel loads the counter from its reload value and raises an underflow flag. An interrupt line per channel follows that flag when the channel's enable bit is set. A single byte-wide run register, below all channel banks, starts and stops every channel with one bit each.

Software uses it in two ways. It can preload the counter with a first timeout and the reload value with a period, giving periodic events; acknowledging means rewriting the control word with the flag bit cleared. It can also leave the reload value at all ones and let the channel run freely, so that the bitwise inverse of the counter is an up-counting time base. Reads are combinational on the address. A write takes effect at the clock edge where `bus_wen` is high.

Top module: `cdt_timer`

## Requirements
- R1: The run register sits at byte address 0x00. Bit n starts channel n when set and stops it when clear. Bits at or above the channel count are not stored and read as 0.
- R2: Channel c's bank starts at byte address 0x04 + 0x10·c. The reload value is at bank offset 0, the counter at offset 4 and the control word at offset 8. Offset 12, any address past the last bank, and any address with bits [1:0] non-zero read 0 and are ignored on write.
- R3: A running channel decrements its counter on every fourth clock edge. The first decrement falls on the fourth edge after the edge that wrote the run bit.
- R4: On a count tick with the counter at 0, the counter loads the reload value and the underflow flag (control bit 8) is set.
- R5: A stopped channel holds its counter, and its divider restarts from zero. After a restart, the first decrement again comes on the fourth edge.
- R6: The counter and the reload value are written independently, at any time. A counter write shows on the next cycle and takes priority over a count tick on the same edge.
- R7: Control bit 5 enables the interrupt. `irq[c]` is high exactly when channel c's flag and its enable bit are both 1. Control bits other than 5 and 8 read 0.
- R8: A control write with bit 8 = 0 clears the flag. A write with bit 8 = 1 leaves the flag unchanged and never sets it. An underflow on the same edge as a clearing write leaves the flag set.
- R9: After reset, every counter and reload value is 0xFFFFFFFF, every control word is 0 and the run register is 0.
- R10: With the reload value at 0xFFFFFFFF, the inverse of a running counter equals the number of count ticks since it started from all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wen | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | NUM_CH | Per-channel interrupt, flag AND enable |

## Verification
The counting path is driven with four patterns:
- A short first timeout followed by a longer reload value. This separates the first period from every later one and fixes the exact edge where the interrupt rises.
- A stop, a counter rewrite and then a restart. This shows whether the divider really clears or only pauses.
- A free run from all ones for a few hundred cycles. This exposes any off-by-one in the tick rate.
- A clearing control write placed on the very edge of an underflow. This tells "set wins" apart from "clear wins".

Reserved offsets, misaligned addresses and run bits above the channel count are probed to confirm that writes to them leave every visible register unchanged.

// File: rtl/cdt_pkg.sv
// Shared definitions for the down-counter timer: register selectors,
// control-word bit positions and the fixed address layout.
// Assumes a byte-addressed 8-bit address space with 32-bit registers.
package cdt_pkg;
    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int IE_BIT   = 5;   // interrupt enable
    localparam int FLAG_BIT = 8;   // underflow flag

    localparam logic [5:0] RUN_WORD   = 6'd0;   // run register, word address
    localparam logic [5:0] BANK0_WORD = 6'd1;   // first bank, word address
endpackage

// File: rtl/cdt_divider.sv
// Count-rate divider for one channel. It emits a one-cycle tick every
// DIV cycles while run is high and clears whenever run is low, so a
// restart always begins a full period. Assumes DIV >= 2.
module cdt_divider #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = $clog2(DIV);

    logic [PW-1:0] phase_q;

    assign tick = run && (phase_q == PW'(DIV - 1));

    // Advance the phase while running; wrap on tick; clear when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) phase_q <= '0;
        else                        phase_q <= phase_q + 1'b1;
    end

    // A stop leaves no tick pending on the next cycle.
    a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);
endmodule

// File: rtl/cdt_decode.sv
// Address decode for the timer. The run register is word 0. Bank c
// starts at word 1 + 4c, and its words hold reload, count and control.
// Assumes NUM_CH <= 8. Misaligned addresses decode to nothing.
module cdt_decode
    import cdt_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CH_W   = 2
) (
    input  logic [7:0]      addr,
    output logic            hit_run,
    output logic            hit_bank,
    output logic [CH_W-1:0] ch_idx,
    output reg_sel_e        sel
);
    logic [5:0] word;
    logic [5:0] rel;
    logic       aligned;

    // Split the address into bank number and register word.
    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        word     = addr[7:2];
        rel      = word - BANK0_WORD;
        hit_run  = aligned && (word == RUN_WORD);
        hit_bank = aligned && (word >= BANK0_WORD)
                   && (int'(rel[5:2]) < NUM_CH) && (rel[1:0] != 2'd3);
        ch_idx   = rel[CH_W+1:2];
        sel      = hit_bank ? reg_sel_e'(rel[1:0]) : SEL_NONE;
    end
endmodule

// File: rtl/cdt_channel.sv
// One timer channel: counter, reload value, interrupt enable and
// underflow flag. Counter writes beat count ticks. An underflow beats a
// clearing control write. Assumes the write strobes are one-hot.
module cdt_channel
    import cdt_pkg::*;
#(
    parameter int DW  = 32,
    parameter int DIV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          reload_we,
    input  logic          count_we,
    input  logic          ctrl_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] count_q,
    output logic [DW-1:0] reload_q,
    output logic [15:0]   ctrl_rd,
    output logic          irq
);
    logic tick;
    logic ie_q;
    logic flag_q;
    logic wrap;

    cdt_divider #(.DIV(DIV)) i_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    assign wrap = tick && (count_q == '0);

    // Counter: software write first, else reload on wrap, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '1;
        else if (count_we) count_q <= wdata;
        else if (wrap)     count_q <= reload_q;
        else if (tick)     count_q <= count_q - 1'b1;
    end

    // Reload value: software-written only.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '1;
        else if (reload_we) reload_q <= wdata;
    end

    // Control: enable follows writes; the flag is set by wrap and cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (ctrl_we) ie_q <= wdata[IE_BIT];
            if (wrap)                              flag_q <= 1'b1;
            else if (ctrl_we && !wdata[FLAG_BIT])  flag_q <= 1'b0;
        end
    end

    // Present the control word and the interrupt.
    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[IE_BIT]   = ie_q;
        ctrl_rd[FLAG_BIT] = flag_q;
        irq               = flag_q && ie_q;
    end

    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_q != '0 && !count_we) |=> count_q == $past(count_q) - 1'b1);
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_q == '0 && !count_we) |=> (count_q == $past(reload_q)) && flag_q);
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !count_we) |=> $stable(count_q));
    a_r8_no_write_set: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && count_q == '0) |=> !$rose(flag_q));
endmodule

// File: rtl/cdt_timer.sv
// Top of the multi-channel down-counter timer. It holds the shared run
// register, decodes the bus, fans write strobes out to the channels and
// muxes read data back. Assumes NUM_CH between 1 and 8.
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int         CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [7:0] RUN_MASK = 8'((1 << NUM_CH) - 1);

    logic            hit_run;
    logic            hit_bank;
    logic [CH_W-1:0] ch_idx;
    reg_sel_e        sel;
    logic [7:0]      run_q;

    logic [31:0] ch_count  [NUM_CH];
    logic [31:0] ch_reload [NUM_CH];
    logic [15:0] ch_ctrl   [NUM_CH];

    cdt_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_dec (
        .addr    (bus_addr),
        .hit_run (hit_run),
        .hit_bank(hit_bank),
        .ch_idx  (ch_idx),
        .sel     (sel)
    );

    // Shared run register; bits without a channel are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                  run_q <= '0;
        else if (bus_wen && hit_run) run_q <= bus_wdata[7:0] & RUN_MASK;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic mine;
        assign mine = bus_wen && hit_bank && (int'(ch_idx) == c);

        cdt_channel #(.DW(32), .DIV(DIV)) i_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q[c]),
            .reload_we(mine && (sel == SEL_RELOAD)),
            .count_we (mine && (sel == SEL_COUNT)),
            .ctrl_we  (mine && (sel == SEL_CTRL)),
            .wdata    (bus_wdata),
            .count_q  (ch_count[c]),
            .reload_q (ch_reload[c]),
            .ctrl_rd  (ch_ctrl[c]),
            .irq      (irq[c])
        );
    end

    // Read mux over the run register and the selected channel word.
    always_comb begin
        bus_rdata = '0;
        if (hit_run) begin
            bus_rdata[7:0] = run_q;
        end else if (hit_bank) begin
            case (sel)
                SEL_RELOAD: bus_rdata = ch_reload[ch_idx];
                SEL_COUNT:  bus_rdata = ch_count[ch_idx];
                SEL_CTRL:   bus_rdata = {16'b0, ch_ctrl[ch_idx]};
                default:    bus_rdata = '0;
            endcase
        end
    end

    a_r1_unused_bits: assert property (@(posedge clk) disable iff (!rst_n)
        hit_run |-> (bus_rdata[31:NUM_CH] == '0));
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_run && !hit_bank) |-> (bus_rdata == '0));
endmodule

// File: tb/test_cdt_timer.sv
module test_cdt_timer;
    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wen = 1'b0;
    logic [7:0]     bus_addr = 8'h00;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    cdt_timer #(.NUM_CH(NCH), .DIV(4)) i_cdt_timer (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_cnt [NCH];
    logic [31:0] m_rel [NCH];
    bit          m_ie  [NCH];
    bit          m_fl  [NCH];
    int          m_ph  [NCH];
    logic [7:0]  m_run;

    function automatic bit hits(input logic [7:0] a, input int ch, input int k);
        int w;
        if (a[1:0] != 0 || a < 8'h04) return 0;
        w = (int'(a) - 4) / 4;
        return (w / 4 == ch) && (w % 4 == k);
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int w, ch, k;
        if (a[1:0] != 0) return 0;
        if (a < 8'h04) return {24'b0, m_run};
        w = (int'(a) - 4) / 4; ch = w / 4; k = w % 4;
        if (ch >= NCH) return 0;
        case (k)
            0: return m_rel[ch];
            1: return m_cnt[ch];
            2: return (32'(m_fl[ch]) << 8) | (32'(m_ie[ch]) << 5);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            bit tk;
            bit wr_c, wr_r, wr_k;
            tk = 0;
            if (!rst_n) begin
                m_cnt[c] = '1; m_rel[c] = '1; m_ie[c] = 0; m_fl[c] = 0; m_ph[c] = 0;
            end else begin
                wr_r = bus_wen && hits(bus_addr, c, 0);
                wr_c = bus_wen && hits(bus_addr, c, 1);
                wr_k = bus_wen && hits(bus_addr, c, 2);
                if (m_run[c]) begin
                    tk = (m_ph[c] == 3);
                    m_ph[c] = (m_ph[c] + 1) % 4;
                end else m_ph[c] = 0;
                if (tk && m_cnt[c] == 0) m_fl[c] = 1;
                else if (wr_k && !bus_wdata[8]) m_fl[c] = 0;
                if (wr_k) m_ie[c] = bus_wdata[5];
                if (wr_c) m_cnt[c] = bus_wdata;
                else if (tk) m_cnt[c] = (m_cnt[c] == 0) ? m_rel[c] : m_cnt[c] - 1;
                if (wr_r) m_rel[c] = bus_wdata;
            end
        end
        if (!rst_n) m_run = 0;
        else if (bus_wen && bus_addr[7:2] == 0) m_run = bus_wdata[7:0] & 8'h07;
    end

    function automatic string tag_of(input logic [7:0] a);
        if (a < 8'h04) return "R1";
        case (((int'(a) - 4) / 4) % 4)
            0: return "R6";
            1: return "R3";
            2: return "R7";
            default: return "R2";
        endcase
    endfunction

    // Compare the design with the model on every clock.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] er;
            er = m_read(bus_addr);
            checks++;
            if (bus_rdata !== er) begin
                errors++;
                $display("FAIL %s model read @%02h actual=%08h expected=%08h",
                         tag_of(bus_addr), bus_addr, bus_rdata, er);
            end
            for (int c = 0; c < NCH; c++) begin
                checks++;
                if (irq[c] !== (m_fl[c] && m_ie[c])) begin
                    errors++;
                    $display("FAIL R7 irq[%0d] actual=%0b expected=%0b",
                             c, irq[c], m_fl[c] && m_ie[c]);
                end
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wen = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a; #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic edges(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R9 reset state
        rd_check("R9", 8'h00, 32'h0);
        rd_check("R9", 8'h08, 32'hFFFF_FFFF);
        rd_check("R9", 8'h04, 32'hFFFF_FFFF);
        rd_check("R9", 8'h0C, 32'h0);

        // R2 reserved offset, misaligned and out-of-range banks
        wr(8'h10, 32'hDEAD_BEEF);
        rd_check("R2", 8'h10, 32'h0);
        wr(8'h05, 32'h1234_5678);
        rd_check("R2", 8'h04, 32'hFFFF_FFFF);
        rd_check("R2", 8'h34, 32'h0);

        // R1 unused run bits
        wr(8'h00, 32'h0000_00FF);
        rd_check("R1", 8'h00, 32'h07);
        wr(8'h00, 32'h0);
        rd_check("R1", 8'h00, 32'h00);

        // R4/R3 first timeout 2 then reload 5 on channel 1
        wr(8'h14, 32'd5);
        wr(8'h18, 32'd2);
        wr(8'h1C, 32'h20);
        wr(8'h00, 32'h02);
        edges(11);
        check("R4", 32'(irq[1]), 32'h0);
        edges(1);
        check("R4", 32'(irq[1]), 32'h1);
        rd_check("R4", 8'h18, 32'd5);
        rd_check("R4", 8'h1C, 32'h120);

        // R8 acknowledge rules
        wr(8'h1C, 32'h120);
        rd_check("R8", 8'h1C, 32'h120);
        wr(8'h1C, 32'h020);
        rd_check("R8", 8'h1C, 32'h020);
        check("R8", 32'(irq[1]), 32'h0);
        wr(8'h1C, 32'h000);
        edges(30);
        rd_check("R7", 8'h1C, 32'h100);
        check("R7", 32'(irq[1]), 32'h0);

        // R5 stop holds, restart begins a full divide period
        wr(8'h00, 32'h0);
        bus_addr = 8'h18; #1;
        begin
            logic [31:0] held;
            held = bus_rdata;
            edges(40);
            rd_check("R5", 8'h18, held);
        end
        wr(8'h18, 32'd7);
        wr(8'h00, 32'h02);
        edges(3);
        rd_check("R5", 8'h18, 32'd7);
        edges(1);
        rd_check("R3", 8'h18, 32'd6);

        // R6 counter write while running
        wr(8'h18, 32'h100);
        rd_check("R6", 8'h18, 32'h100);

        // R10 free run from all ones on channel 0
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h01);
        edges(400);
        bus_addr = 8'h08; #1;
        check("R10", ~bus_rdata, 32'd100);

        // R8 underflow on the same edge as a clearing write
        wr(8'h00, 32'h0);
        wr(8'h24, 32'd3);
        wr(8'h28, 32'd0);
        wr(8'h2C, 32'h20);
        wr(8'h00, 32'h04);
        edges(2);
        wr(8'h2C, 32'h0);
        rd_check("R8", 8'h2C, 32'h100);
        rd_check("R4", 8'h28, 32'd3);
        check("R8", 32'(irq[2]), 32'h0);

        edges(5);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule